// File: doc/BRIEF.md
# Waveform Sequence Loop Controller

This block decides which waveform plays next, and how often. A list of up to eight slot entries describes the playback. Each entry names a waveform to play, inserts a timed pause, or marks the end of the list. Each slot has a 4-bit repeat code. The whole list has a 4-bit main repeat code. The controller advances only on a sample tick. Every tick spent in a waveform slot produces one play strobe, which tells a downstream fetch engine to play that waveform once. Waveform storage, sample fetching and the output stage are outside this block.

A start request begins a run at slot 0. The run ends in one of two ways. It finishes by itself once the last main pass is complete, and a done pulse is issued. Or it is aborted by a stop request. The repeat codes are read live. A slot or list that was set to repeat forever can therefore be released by rewriting its code to a finite value while it plays.

Top module: `wave_seq_loop`

## Requirements
- R1: When idle (busy low), `go` makes busy high on the next clock and the run starts at slot 0. `go` while busy has no effect on the run.
- R2: Each slot entry is 8 bits. Bit 7 = 0 with bits 6:0 nonzero means play waveform id bits 6:0. When the controller handles such a slot on a sample tick, `playStrobe` is high for exactly the next clock cycle, with `playWave` set to the id and `playSlot` set to the slot index.
- R3: A slot repeat code c from 0 to 14 plays that slot c+1 times, on consecutive ticks, before the controller moves to the next slot.
- R4: Slot code 15 repeats the slot without end. If the code reads finite on a tick where the slot has already played at least that many extra times, that tick plays the slot once more and then moves on.
- R5: The main code m from 0 to 14 runs the list m+1 times. Code 15 runs it without end, until stop or until the code is rewritten to a finite value, which ends the run at the next end of list.
- R6: An entry of 8'h00, or stepping past the last slot, ends a main pass. This consumes one tick with no strobe. The next pass restarts at slot 0.
- R7: An entry with bit 7 = 1 is a wait of N = bits 6:0 steps. The wait select 0,1,2,3 gives a step of 1, 8, 64 or 512 ticks. A wait with N > 0 holds for N*step ticks after its own tick, with no strobe. A wait with N = 0 only consumes its own tick.
- R8: `stop` seen on a sample tick while busy makes busy low on the next clock, with no strobe and no done pulse.
- R9: When the final pass completes, on that end-of-list tick, `done` is high for exactly one clock and busy is low in that same clock.
- R10: Slot repeat codes are packed two per byte of `loopCodes`. Slot 2k uses bits 7:4 of byte k, and slot 2k+1 uses bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start request, taken only when idle |
| stop | input | 1 | Abort request, acted on at a sample tick |
| sampleTick | input | 1 | One-cycle pulse, once per sample period |
| seqEntries | input | NUM_SLOTS*8 | Slot entries, slot s in bits s*8+7:s*8 |
| loopCodes | input | NUM_SLOTS*4 | Slot repeat codes, two per byte |
| mainLoop | input | 4 | Main list repeat code |
| waitUnit | input | 2 | Wait step select (1/8/64/512 ticks) |
| busy | output | 1 | A run is in progress |
| playStrobe | output | 1 | Play one pass of `playWave` |
| playWave | output | 7 | Waveform id of the current strobe |
| playSlot | output | IDX_W | Slot index of the current strobe |
| done | output | 1 | One-cycle pulse when a run finishes |

## Verification
Random lists mix play, wait, zero-wait and end entries with small repeat codes, main codes and wait steps. These are compared strobe by strobe against a tick-exact model, so an off-by-one in any counter shows up as a wrong tick index. Directed lists cover a list with no end marker, an empty list and the two long wait steps. Together they separate end-by-marker from end-by-overflow and catch a wrong wait shift. Live rewrites of an infinite slot code and of an infinite main code check that the release happens exactly one pass later. A stop during an endless run, and a start pulse in the middle of a run, show that the abort path and the ignored start leave no strobe or done behind.

// File: rtl/wave_seq_pkg.sv
package wave_seq_pkg;

  localparam int ENTRY_W  = 8;
  localparam int CODE_W   = 4;
  localparam int COUNT_W  = 7;
  localparam int MAX_SH   = 9;
  localparam int WAIT_W   = COUNT_W + MAX_SH;
  localparam logic [CODE_W-1:0] CODE_INF = '1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_WAIT
  } seqState_t;

  typedef struct packed {
    logic slotClr;
    logic slotInc;
    logic repClr;
    logic repInc;
    logic mainClr;
    logic mainInc;
    logic waitLoad;
    logic waitDec;
    logic play;
  } seqCtrl_t;

  typedef struct packed {
    logic atEnd;
    logic isWait;
    logic waitZero;
    logic slotMore;
    logic mainMore;
    logic waitLast;
  } seqStat_t;

endpackage

// File: rtl/wave_seq_ctrl.sv
module wave_seq_ctrl
  import wave_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     go,
  input  logic     stop,
  input  logic     sampleTick,
  input  seqStat_t stat,
  output seqCtrl_t ctrl,
  output logic     busy,
  output logic     done
);

  seqState_t state, nextState;
  logic doneSet;

  always_comb begin
    ctrl      = '0;
    nextState = state;
    doneSet   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (go) begin
          ctrl.slotClr = 1'b1;
          ctrl.repClr  = 1'b1;
          ctrl.mainClr = 1'b1;
          nextState    = ST_RUN;
        end
      end
      ST_RUN: begin
        if (sampleTick) begin
          if (stop) begin
            nextState = ST_IDLE;
          end else if (stat.atEnd) begin
            if (stat.mainMore) begin
              ctrl.mainInc = 1'b1;
              ctrl.slotClr = 1'b1;
              ctrl.repClr  = 1'b1;
            end else begin
              nextState = ST_IDLE;
              doneSet   = 1'b1;
            end
          end else if (stat.isWait) begin
            if (stat.waitZero) begin
              ctrl.slotInc = 1'b1;
              ctrl.repClr  = 1'b1;
            end else begin
              ctrl.waitLoad = 1'b1;
              nextState     = ST_WAIT;
            end
          end else begin
            ctrl.play = 1'b1;
            if (stat.slotMore) begin
              ctrl.repInc = 1'b1;
            end else begin
              ctrl.repClr  = 1'b1;
              ctrl.slotInc = 1'b1;
            end
          end
        end
      end
      ST_WAIT: begin
        if (sampleTick) begin
          if (stop) begin
            nextState = ST_IDLE;
          end else if (stat.waitLast) begin
            ctrl.slotInc = 1'b1;
            ctrl.repClr  = 1'b1;
            nextState    = ST_RUN;
          end else begin
            ctrl.waitDec = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= doneSet;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/wave_seq_dp.sv
module wave_seq_dp
  import wave_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_SLOTS*ENTRY_W-1:0]  seqEntries,
  input  logic [NUM_SLOTS*CODE_W-1:0]   loopCodes,
  input  logic [CODE_W-1:0]             mainLoop,
  input  logic [1:0]                    waitUnit,
  input  seqCtrl_t                      ctrl,
  output seqStat_t                      stat,
  output logic                          playStrobe,
  output logic [COUNT_W-1:0]            playWave,
  output logic [IDX_W-1:0]              playSlot
);

  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0]   slotPtr;
  logic [CODE_W-1:0]  repCnt;
  logic [CODE_W-1:0]  mainCnt;
  logic [WAIT_W-1:0]  waitRem;

  logic [ENTRY_W-1:0] entryArr [NUM_SLOTS];
  logic [CODE_W-1:0]  codeArr  [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign entryArr[g] = seqEntries[g*ENTRY_W +: ENTRY_W];
    assign codeArr[g]  = loopCodes[(g/2)*8 + (((g%2) == 0) ? 4 : 0) +: CODE_W];
  end

  logic [IDX_W-1:0]   slotIdx;
  logic               pastEnd;
  logic [ENTRY_W-1:0] curEntry;
  logic [CODE_W-1:0]  curCode;
  logic [3:0]         shiftAmt;
  logic [WAIT_W-1:0]  waitTicks;

  assign slotIdx   = slotPtr[IDX_W-1:0];
  assign pastEnd   = (slotPtr == PTR_W'(NUM_SLOTS));
  assign curEntry  = entryArr[slotIdx];
  assign curCode   = codeArr[slotIdx];
  assign shiftAmt  = 4'(waitUnit) * 4'd3;
  assign waitTicks = WAIT_W'(curEntry[COUNT_W-1:0]) << shiftAmt;

  assign stat.atEnd    = pastEnd || (curEntry == '0);
  assign stat.isWait   = curEntry[ENTRY_W-1];
  assign stat.waitZero = (curEntry[COUNT_W-1:0] == '0);
  assign stat.slotMore = (curCode == CODE_INF) || (repCnt < curCode);
  assign stat.mainMore = (mainLoop == CODE_INF) || (mainCnt < mainLoop);
  assign stat.waitLast = (waitRem == WAIT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotPtr    <= '0;
      repCnt     <= '0;
      mainCnt    <= '0;
      waitRem    <= '0;
      playStrobe <= 1'b0;
      playWave   <= '0;
      playSlot   <= '0;
    end else begin
      if (ctrl.slotClr)      slotPtr <= '0;
      else if (ctrl.slotInc) slotPtr <= slotPtr + PTR_W'(1);

      if (ctrl.repClr)                          repCnt <= '0;
      else if (ctrl.repInc && repCnt != '1)     repCnt <= repCnt + CODE_W'(1);

      if (ctrl.mainClr)                         mainCnt <= '0;
      else if (ctrl.mainInc && mainCnt != '1)   mainCnt <= mainCnt + CODE_W'(1);

      if (ctrl.waitLoad)     waitRem <= waitTicks;
      else if (ctrl.waitDec) waitRem <= waitRem - WAIT_W'(1);

      playStrobe <= ctrl.play;
      if (ctrl.play) begin
        playWave <= curEntry[COUNT_W-1:0];
        playSlot <= slotIdx;
      end
    end
  end

endmodule

// File: rtl/wave_seq_loop.sv
module wave_seq_loop
  import wave_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         go,
  input  logic                         stop,
  input  logic                         sampleTick,
  input  logic [NUM_SLOTS*8-1:0]       seqEntries,
  input  logic [NUM_SLOTS*4-1:0]       loopCodes,
  input  logic [3:0]                   mainLoop,
  input  logic [1:0]                   waitUnit,
  output logic                         busy,
  output logic                         playStrobe,
  output logic [6:0]                   playWave,
  output logic [IDX_W-1:0]             playSlot,
  output logic                         done
);

  seqCtrl_t ctrl;
  seqStat_t stat;

  wave_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .go         (go),
    .stop       (stop),
    .sampleTick (sampleTick),
    .stat       (stat),
    .ctrl       (ctrl),
    .busy       (busy),
    .done       (done)
  );

  wave_seq_dp #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .seqEntries (seqEntries),
    .loopCodes  (loopCodes),
    .mainLoop   (mainLoop),
    .waitUnit   (waitUnit),
    .ctrl       (ctrl),
    .stat       (stat),
    .playStrobe (playStrobe),
    .playWave   (playWave),
    .playSlot   (playSlot)
  );

endmodule

// File: rtl/wave_seq_loop_chk.sv
module wave_seq_loop_chk (
  input logic       clk,
  input logic       rstN,
  input logic       go,
  input logic       stop,
  input logic       sampleTick,
  input logic       busy,
  input logic       playStrobe,
  input logic [6:0] playWave,
  input logic       done
);

  // R1
  go_starts_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && go) |=> busy);

  // R2
  strobe_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    playStrobe |-> ($past(sampleTick) && $past(busy)));

  // R2
  strobe_wave_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    playStrobe |-> (playWave != 7'd0));

  // R8
  stop_aborts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sampleTick && stop) |=> (!busy && !playStrobe && !done));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind wave_seq_loop wave_seq_loop_chk u_chk (.*);

// File: tb/wave_seq_loop_bench.sv
module wave_seq_loop_bench;

  localparam int NS   = 8;
  localparam int MAXE = 1024;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          go = 1'b0;
  logic          stop = 1'b0;
  logic          sampleTick = 1'b0;
  logic [NS*8-1:0] seqEntries = '0;
  logic [NS*4-1:0] loopCodes = '0;
  logic [3:0]    mainLoop = '0;
  logic [1:0]    waitUnit = '0;
  logic          busy;
  logic          playStrobe;
  logic [6:0]    playWave;
  logic [2:0]    playSlot;
  logic          done;

  wave_seq_loop u_wave_seq_loop (
    .clk(clk), .rstN(rstN), .go(go), .stop(stop), .sampleTick(sampleTick),
    .seqEntries(seqEntries), .loopCodes(loopCodes), .mainLoop(mainLoop),
    .waitUnit(waitUnit), .busy(busy), .playStrobe(playStrobe),
    .playWave(playWave), .playSlot(playSlot), .done(done)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int ent [NS];
  int code [NS];
  int mainC;
  int unitSel;

  int expN;
  int expDone;
  int expSlot [MAXE];
  int expWave [MAXE];
  int expTick [MAXE];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R10: slot 2k in bits 7:4 of byte k, slot 2k+1 in bits 3:0
  task automatic applyConfig();
    for (int s = 0; s < NS; s++) begin
      seqEntries[s*8 +: 8] = ent[s][7:0];
      loopCodes[(s/2)*8 + ((s%2 == 0) ? 4 : 0) +: 4] = code[s][3:0];
    end
    mainLoop = mainC[3:0];
    waitUnit = unitSel[1:0];
  endtask

  function automatic int stepTicks(int u);
    return 1 << (3 * u);
  endfunction

  task automatic computeExpected();
    int k = 0;
    expN = 0;
    for (int pass = 0; pass <= mainC; pass++) begin
      for (int s = 0; s < NS; s++) begin
        if (ent[s] == 0) break;
        if (ent[s] >= 128) begin
          if ((ent[s] & 127) == 0) k += 1;
          else k += (ent[s] & 127) * stepTicks(unitSel) + 1;
        end else begin
          for (int r = 0; r <= code[s]; r++) begin
            if (expN < MAXE) begin
              expSlot[expN] = s; expWave[expN] = ent[s]; expTick[expN] = k;
            end
            expN++;
            k++;
          end
        end
      end
      expDone = k;
      k++;
    end
  endtask

  task automatic doTick();
    @(negedge clk) sampleTick = 1'b1;
    @(negedge clk) sampleTick = 1'b0;
  endtask

  task automatic startRun();
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    check(busy == 1'b1, "R1", "busy after go", int'(busy), 1);
  endtask

  task automatic runCase(input string name, input int goMidAt);
    int nPlay = 0;
    bit seenDone = 0;
    computeExpected();
    applyConfig();
    startRun();
    for (int k = 0; k < 20000 && !seenDone; k++) begin
      @(negedge clk) begin
        sampleTick = 1'b1;
        if (k == goMidAt) go = 1'b1;
      end
      @(negedge clk) begin
        sampleTick = 1'b0;
        go = 1'b0;
      end
      if (playStrobe) begin
        if (nPlay < expN && nPlay < MAXE) begin
          check(playSlot == expSlot[nPlay][2:0], "R3", {name, " slot"}, int'(playSlot), expSlot[nPlay]);
          check(playWave == expWave[nPlay][6:0], "R2", {name, " wave"}, int'(playWave), expWave[nPlay]);
          check(k == expTick[nPlay], "R7", {name, " strobe tick"}, k, expTick[nPlay]);
        end else begin
          check(1'b0, "R6", {name, " extra strobe"}, nPlay, expN);
        end
        nPlay++;
      end
      if (done) begin
        seenDone = 1;
        check(k == expDone, "R9", {name, " done tick"}, k, expDone);
        check(busy == 1'b0, "R9", {name, " busy at done"}, int'(busy), 0);
      end
    end
    check(seenDone, "R9", {name, " done seen"}, int'(seenDone), 1);
    check(nPlay == expN, "R5", {name, " strobe count"}, nPlay, expN);
    @(negedge clk);
    check(done == 1'b0, "R9", {name, " done one cycle"}, int'(done), 0);
  endtask

  task automatic clearCfg();
    for (int s = 0; s < NS; s++) begin ent[s] = 0; code[s] = 0; end
    mainC = 0;
    unitSel = 0;
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int strobes;
    bit sawDone;
    void'($urandom(32'd20211));
    clearCfg();
    applyConfig();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
    check(playStrobe == 1'b0, "R2", "reset strobe", int'(playStrobe), 0);
    check(done == 1'b0, "R9", "reset done", int'(done), 0);

    // R3 simple list, varied codes, multiple main passes
    clearCfg();
    ent[0] = 11; ent[1] = 22; ent[2] = 33; code[0] = 2; code[1] = 0; code[2] = 1; mainC = 1;
    runCase("R3 basic", -1);

    // R6 no end marker: pass ends after the last slot
    clearCfg();
    for (int s = 0; s < NS; s++) begin ent[s] = s + 1; code[s] = s % 3; end
    mainC = 2;
    runCase("R6 full", -1);

    // R6 empty list
    clearCfg();
    mainC = 2;
    runCase("R6 empty", -1);

    // R7 wait steps of 64 and 512 ticks, plus zero wait
    clearCfg();
    ent[0] = 5; ent[1] = 8'h81; ent[2] = 8'h80; ent[3] = 6;
    unitSel = 2;
    runCase("R7 unit64", -1);
    unitSel = 3;
    runCase("R7 unit512", -1);

    // R1 go during run ignored
    clearCfg();
    ent[0] = 7; ent[1] = 8'h82; ent[2] = 9; code[0] = 3; mainC = 1; unitSel = 1;
    runCase("R1 go mid", 3);

    // R4 infinite slot released by live rewrite
    clearCfg();
    ent[0] = 5; ent[1] = 6; code[0] = 15;
    applyConfig();
    startRun();
    strobes = 0;
    for (int i = 0; i < 20; i++) begin
      doTick();
      if (playStrobe && playSlot == 3'd0) strobes++;
    end
    check(strobes == 20, "R4", "infinite slot strobes", strobes, 20);
    code[0] = 2;
    applyConfig();
    doTick();
    check(playStrobe && playSlot == 3'd0, "R4", "last pass slot0", int'(playSlot), 0);
    doTick();
    check(playStrobe && playSlot == 3'd1, "R4", "moved to slot1", int'(playSlot), 1);
    doTick();
    check(done == 1'b1, "R4", "done after release", int'(done), 1);

    // R8 stop during endless run
    clearCfg();
    ent[0] = 9; code[0] = 15; mainC = 15;
    applyConfig();
    startRun();
    repeat (5) doTick();
    @(negedge clk) begin sampleTick = 1'b1; stop = 1'b1; end
    @(negedge clk) begin sampleTick = 1'b0; stop = 1'b0; end
    check(busy == 1'b0, "R8", "busy after stop", int'(busy), 0);
    check(playStrobe == 1'b0, "R8", "strobe at stop", int'(playStrobe), 0);
    check(done == 1'b0, "R8", "done at stop", int'(done), 0);
    doTick();
    check(playStrobe == 1'b0, "R8", "idle after stop", int'(playStrobe), 0);

    // R5 infinite main released by live rewrite
    clearCfg();
    ent[0] = 3; mainC = 15;
    applyConfig();
    startRun();
    strobes = 0;
    for (int i = 0; i < 10; i++) begin
      doTick();
      if (playStrobe) strobes++;
    end
    check(strobes == 5, "R5", "infinite main strobes", strobes, 5);
    check(busy == 1'b1, "R5", "still busy", int'(busy), 1);
    mainC = 0;
    applyConfig();
    doTick();
    check(playStrobe == 1'b1, "R5", "play before end", int'(playStrobe), 1);
    doTick();
    check(done == 1'b1, "R5", "done after main release", int'(done), 1);

    // random lists
    for (int c = 0; c < 30; c++) begin
      clearCfg();
      for (int s = 0; s < NS; s++) begin
        int r = int'($urandom % 100);
        if (r < 12) ent[s] = 0;
        else if (r < 27) ent[s] = 128 + int'($urandom % 4);
        else ent[s] = 1 + int'($urandom % 127);
        code[s] = int'($urandom % 4);
      end
      mainC = int'($urandom % 3);
      unitSel = int'($urandom % 2);
      runCase("R2 random", (c % 3 == 0) ? 2 : -1);
    end

    sawDone = 0;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule